// File: doc/BRIEF.md
# Multi-Cycle Integer Core Sequencer

This block is the control sequencer and integer datapath of a small 32-bit processor. Each instruction goes through five states in order: fetch, decode, execute, memory access and register writeback. The next fetch begins only after writeback ends. Instruction fetches, loads and stores all use one shared memory port. Every transaction on that port waits until the memory signals ready.

The core has a 32-entry register file. Register 0 always reads as zero, and register 1 is the call/return link. It supports ALU operations, immediate add, word load and store, and two compare branches. It also has a call to a PC-relative target, a call through a register plus an offset, and a fused decrement-and-branch loop. The PC changes in execute, but the link value is written later, in writeback. For this reason the core keeps a copy of the address each instruction was fetched from and forms the link from that copy.

Opcodes outside the supported set raise a sticky illegal flag. The core then stops in a halt state. Instructions for floating-point, vector or quantised units fall into this group.

Top module: `mc_core`

## Requirements
- R1: Every instruction word has the opcode in bits 31:26, the destination/data register in bits 25:21, the first source register in bits 20:16, and a 16-bit sign-extended immediate in bits 15:0. After reset the first fetch is at parameter RESET_PC. Each instruction passes through fetch, decode, execute, memory and writeback before the next fetch.
- R2: Register 0 reads as zero. A write to it is discarded.
- R3: Opcode 0x00 is a register-register operation. It reads the second source register from bits 15:11 and the function code from bits 3:0: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than, 6 shift left, 7 logical shift right (the shift amount is the low 5 bits). Opcode 0x01 adds the immediate to the first source register.
- R4: Opcode 0x02 loads a word from the first source register plus the immediate. Opcode 0x03 stores the register in bits 25:21 to that same address. A transaction holds its request, address and write enable until ready is sampled high.
- R5: Opcode 0x04 branches when the registers in bits 25:21 and 20:16 are equal. Opcode 0x05 branches when they differ. The target is the instruction's own address plus the immediate. Otherwise execution continues at the address plus 4.
- R6: Opcode 0x06 jumps to its own address plus the sign-extended bits 25:0. It writes its own address plus 4 into register 1.
- R7: Opcode 0x07 jumps to the first source register plus the immediate, with the two low target bits cleared. It writes its own address plus 4 into the register in bits 25:21.
- R8: Opcode 0x08 decrements the register in bits 25:21 and writes the result back. It branches to its own address plus the immediate when the result is nonzero.
- R9: Any opcode above 0x08 sets the illegal output. That output stays high until reset, and the core makes no further memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a store |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Fetch or load data |
| mem_ready | input | 1 | Transaction completes at this edge |
| illegal | output | 1 | Sticky illegal-opcode flag; core halted |

## Verification
The bench runs a program of calls and returns. If a core formed the link from the live PC, the stored return address would be the target plus 4, so control would return to the wrong place and the stores after the call would be wrong. A loop that runs three times checks that the loop instruction branches on the decremented value: an off-by-one design would run the body two or four times. The bench also includes a skipped store after a taken branch, a store of register 0 after a write to it, a register call whose target has its low bits set, and memory-ready stalls on every transaction. Any extra or misordered store fails against the expected queue.

// File: rtl/mc_core.sv
module mc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        illegal
);

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_STOP} st_t;

  localparam logic [5:0] OP_ALU = 6'h00, OP_ADDI = 6'h01, OP_LW = 6'h02, OP_SW = 6'h03,
                         OP_BEQ = 6'h04, OP_BNE = 6'h05, OP_JAL = 6'h06, OP_JALR = 6'h07,
                         OP_LOOP = 6'h08;

  st_t         state;
  logic [31:0] pc, pc_f, ir, a, b, res, mdr;
  logic [31:0] rf [32];
  logic        ill_q;

  wire [5:0]  op    = ir[31:26];
  wire [4:0]  rd    = ir[25:21];
  wire [4:0]  rs1   = ir[20:16];
  wire [4:0]  rs2   = ir[15:11];
  wire [31:0] imm   = {{16{ir[15]}}, ir[15:0]};
  wire [31:0] imm26 = {{6{ir[25]}}, ir[25:0]};
  wire        is_mem = (op == OP_LW) || (op == OP_SW);
  wire [31:0] seq_pc = pc_f + 32'd4;
  wire [31:0] br_tgt = (pc_f + imm) & ~32'd3;
  wire [31:0] dec    = b - 32'd1;

  logic [31:0] alu_y;
  always_comb begin
    case (ir[3:0])
      4'd0:    alu_y = a + b;
      4'd1:    alu_y = a - b;
      4'd2:    alu_y = a & b;
      4'd3:    alu_y = a | b;
      4'd4:    alu_y = a ^ b;
      4'd5:    alu_y = {31'd0, $signed(a) < $signed(b)};
      4'd6:    alu_y = a << b[4:0];
      4'd7:    alu_y = a >> b[4:0];
      default: alu_y = 32'd0;
    endcase
  end

  logic        wen;
  logic [4:0]  widx;
  logic [31:0] wval;
  always_comb begin
    wen  = (op == OP_ALU) || (op == OP_ADDI) || (op == OP_LW) || (op == OP_JAL) ||
           (op == OP_JALR) || (op == OP_LOOP);
    widx = (op == OP_JAL) ? 5'd1 : rd;
    if (op == OP_LW)                         wval = mdr;
    else if (op == OP_JAL || op == OP_JALR)  wval = seq_pc;
    else                                     wval = res;
  end

  assign mem_req   = (state == S_FETCH) || (state == S_MEM && is_mem);
  assign mem_we    = (state == S_MEM) && (op == OP_SW);
  assign mem_addr  = (state == S_FETCH) ? pc : res;
  assign mem_wdata = b;
  assign illegal   = ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      pc_f  <= RESET_PC;
      ir    <= 32'd0;
      a     <= 32'd0;
      b     <= 32'd0;
      res   <= 32'd0;
      mdr   <= 32'd0;
      ill_q <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      case (state)
        S_FETCH: if (mem_ready) begin
          ir    <= mem_rdata;
          pc_f  <= pc;
          state <= S_DECODE;
        end
        S_DECODE: begin
          a <= (rs1 == 5'd0) ? 32'd0 : rf[rs1];
          if (op == OP_ALU) b <= (rs2 == 5'd0) ? 32'd0 : rf[rs2];
          else              b <= (rd == 5'd0)  ? 32'd0 : rf[rd];
          if (op > OP_LOOP) begin
            ill_q <= 1'b1;
            state <= S_STOP;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          pc <= seq_pc;
          case (op)
            OP_ALU:  res <= alu_y;
            OP_BEQ:  if (a == b) pc <= br_tgt;
            OP_BNE:  if (a != b) pc <= br_tgt;
            OP_JAL:  pc <= (pc_f + imm26) & ~32'd3;
            OP_JALR: pc <= (a + imm) & ~32'd3;
            OP_LOOP: begin
              res <= dec;
              if (dec != 32'd0) pc <= br_tgt;
            end
            default: res <= a + imm;
          endcase
          state <= S_MEM;
        end
        S_MEM: begin
          if (!is_mem) state <= S_WB;
          else if (mem_ready) begin
            if (op == OP_LW) mdr <= mem_rdata;
            state <= S_WB;
          end
        end
        S_WB: begin
          if (wen && widx != 5'd0) rf[widx] <= wval;
          state <= S_FETCH;
        end
        default: state <= S_STOP;
      endcase
    end
  end

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  ill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req);

  // R6
  linkpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC) |=> $stable(pc_f));

  // R1
  wb_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB) |=> (state == S_FETCH));

endmodule

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, illegal;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rdy = 1'b0;
  logic [31:0] cyc = 32'd0;
  logic [31:0] mem [0:511];
  int          n_chk = 0, n_fail = 0;
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];

  always #4 clk = ~clk;

  mc_core #(.RESET_PC(32'h40)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(rdy), .illegal(illegal)
  );

  assign mem_rdata = mem[mem_addr[10:2]];

  always @(posedge clk) begin
    cyc <= cyc + 32'd1;
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= mem_req && !rdy && (cyc[1:0] != 2'b01);
  end

  function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] rd,
                                     input logic [4:0] rs1, input logic [15:0] imm);
    return {op, rd, rs1, imm};
  endfunction

  function automatic logic [31:0] er(input logic [4:0] rd, input logic [4:0] rs1,
                                     input logic [4:0] rs2, input logic [3:0] fn);
    return {6'h00, rd, rs1, rs2, 7'd0, fn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] addr, input logic [31:0] w);
    mem[addr[10:2]] = w;
  endtask

  task automatic exp_st(input logic [31:0] addr, input logic [31:0] data);
    q_addr.push_back(addr);
    q_data.push_back(data);
  endtask

  // monitor: compare every completed store against the expected queue
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && rdy) begin
      if (q_addr.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5 unexpected store actual=%h:%h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [31:0] ea, ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        chk("R4 store address", mem_addr, ea);
        chk("R1-program store data", mem_wdata, ed);
      end
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'd0;
    put(32'h500, 32'h12345678);
    put(32'h40, ei(6'h01, 5'd2, 5'd0, 16'd5));
    put(32'h44, ei(6'h01, 5'd3, 5'd0, 16'hFFFD));
    put(32'h48, er(5'd4, 5'd2, 5'd3, 4'd0));
    put(32'h4C, ei(6'h03, 5'd4, 5'd0, 16'h0400));  exp_st(32'h400, 32'd2);          // R3 add
    put(32'h50, er(5'd4, 5'd2, 5'd3, 4'd1));
    put(32'h54, ei(6'h03, 5'd4, 5'd0, 16'h0404));  exp_st(32'h404, 32'd8);          // R3 sub
    put(32'h58, er(5'd5, 5'd3, 5'd2, 4'd5));
    put(32'h5C, ei(6'h03, 5'd5, 5'd0, 16'h0408));  exp_st(32'h408, 32'd1);          // R3 slt
    put(32'h60, er(5'd5, 5'd3, 5'd2, 4'd7));
    put(32'h64, ei(6'h03, 5'd5, 5'd0, 16'h040C));  exp_st(32'h40C, 32'h07FFFFFF);   // R3 srl
    put(32'h68, ei(6'h01, 5'd0, 5'd2, 16'd7));
    put(32'h6C, ei(6'h03, 5'd0, 5'd0, 16'h0410));  exp_st(32'h410, 32'd0);          // R2
    put(32'h70, ei(6'h02, 5'd6, 5'd0, 16'h0500));
    put(32'h74, ei(6'h01, 5'd6, 5'd6, 16'd1));
    put(32'h78, ei(6'h03, 5'd6, 5'd0, 16'h0414));  exp_st(32'h414, 32'h12345679);   // R4 load
    put(32'h7C, ei(6'h04, 5'd2, 5'd2, 16'd8));
    put(32'h80, ei(6'h03, 5'd2, 5'd0, 16'h0418));                                    // R5 skipped
    put(32'h84, ei(6'h05, 5'd2, 5'd2, 16'd8));
    put(32'h88, ei(6'h01, 5'd7, 5'd0, 16'd3));
    put(32'h8C, ei(6'h01, 5'd8, 5'd0, 16'd0));
    put(32'h90, ei(6'h01, 5'd8, 5'd8, 16'd10));
    put(32'h94, ei(6'h08, 5'd7, 5'd0, 16'hFFFC));
    put(32'h98, ei(6'h03, 5'd8, 5'd0, 16'h0418));  exp_st(32'h418, 32'd30);         // R8 body count
    put(32'h9C, ei(6'h03, 5'd7, 5'd0, 16'h041C));  exp_st(32'h41C, 32'd0);          // R8 counter
    put(32'hA0, {6'h06, 26'h00000C0});
    put(32'h160, ei(6'h03, 5'd1, 5'd0, 16'h0420)); exp_st(32'h420, 32'hA4);         // R6 link
    put(32'h164, ei(6'h07, 5'd0, 5'd1, 16'd0));
    put(32'hA4, ei(6'h03, 5'd1, 5'd0, 16'h0424));  exp_st(32'h424, 32'hA4);         // R6 return
    put(32'hA8, ei(6'h01, 5'd10, 5'd0, 16'h0180));
    put(32'hAC, ei(6'h07, 5'd11, 5'd10, 16'd6));
    put(32'h184, ei(6'h03, 5'd10, 5'd0, 16'h0428)); exp_st(32'h428, 32'h180);       // R7 target
    put(32'h188, ei(6'h07, 5'd0, 5'd11, 16'd0));
    put(32'hB0, ei(6'h03, 5'd11, 5'd0, 16'h042C)); exp_st(32'h42C, 32'hB0);         // R7 link
    put(32'hB4, 32'hFC000000);

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req", {31'd0, mem_req}, 32'd1);
    chk("R1 reset addr", mem_addr, 32'h40);
    chk("R9 reset flag", {31'd0, illegal}, 32'd0);

    begin
      int wd;
      wd = 0;
      while (!illegal && wd < 20000) begin
        @(negedge clk);
        wd++;
      end
      if (!illegal) begin
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=running expected=halted");
      end
    end

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R9 halted no request", {31'd0, mem_req}, 32'd0);
      chk("R9 sticky flag", {31'd0, illegal}, 32'd1);
    end
    chk("R5 all stores seen", q_addr.size(), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule